// File: doc/BRIEF.md
# Vector Load/Store Address Generator

This block turns one vector memory instruction into a stream of per-element memory addresses. A start pulse captures the addressing mode, a base address, a signed stride and a vector length. The block then emits one element address per accepted handshake on its output stream, in increasing element order, together with the element number, a last marker and the matching byte address. The same sequence serves loads and stores. Moving data, the memory itself and register write-back are handled elsewhere.

Three addressing modes are supported. In the contiguous mode, consecutive elements take consecutive element addresses. In the strided mode, each element steps by a signed scalar stride. In the indexed (gather/scatter) mode, each element's offset is read from an index vector through a side port. The block drives the element number on that port and reads the index value back in the same cycle.

The output stream uses valid/ready. Valid is high for the whole run. An address is consumed on a cycle where valid and ready are both high. While ready is low, every output field holds its value and the element counter does not move. A start pulse is only taken while the block is idle.

Top module: `vec_agu`

## Requirements
- R1: After reset, `out_valid_o`, `busy_o` and `done_o` are 0.
- R2: A start pulse is taken only while `busy_o` is 0. When it is taken and the length is nonzero, `out_valid_o` is 1 with element 0 from the next cycle on. A start pulse while busy has no effect on the running sequence.
- R3: Mode encoding: 0 selects contiguous, 1 selects strided, 2 selects indexed, and 3 behaves as contiguous. In contiguous mode, element i has address base + i, modulo 2^32.
- R4: In strided mode, element i has address base + i × stride, where the stride is a signed 32-bit value and the result is taken modulo 2^32.
- R5: In indexed mode, element i has address base + idx_val_i, and `idx_elem_o` equals the current element number whenever `out_valid_o` is 1. In the other modes, `idx_val_i` has no effect on any output.
- R6: `out_byte_addr_o` equals the element address shifted left by 3 (8-byte elements), modulo 2^32.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, the address, element number and last flag hold their values. The element number rises by exactly one per accepted handshake.
- R8: `out_last_o` is 1 only on element length-1. After that element is accepted, `out_valid_o` is 0 and `done_o` pulses for exactly one cycle.
- R9: A length of 0 produces no valid cycle, and `done_o` pulses in the cycle after the start.
- R10: A length above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken while idle |
| mode_i | input | 2 | Addressing mode (0 contiguous, 1 strided, 2 indexed) |
| base_i | input | 32 | Base element address |
| stride_i | input | 32 | Signed element stride |
| vlen_i | input | 7 | Vector length, clamped to 64 |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence finishes |
| idx_elem_o | output | 6 | Element number for the index read |
| idx_val_i | input | 32 | Signed index value for `idx_elem_o` |
| out_valid_o | output | 1 | Address stream valid |
| out_ready_i | input | 1 | Address stream ready |
| out_addr_o | output | 32 | Element address |
| out_byte_addr_o | output | 32 | Byte address (element address × 8) |
| out_elem_o | output | 6 | Element number |
| out_last_o | output | 1 | Final element of the sequence |

## Verification
The bench targets the following corner cases:
- **Zero length.** A design that handles it wrongly would emit one stray address, or never raise done.
- **Over-long length.** A design that does not clamp it would run past 64 elements or wrap the element counter.
- **Negative strides and address wrap-around.** A design with signed or carry errors would give wrong high bits.
- **Stalls under back-pressure.** A design that gets them wrong would skip or repeat elements, or let the address drift.
- **Start pulses while busy.** A design that accepts them would corrupt the running base.
- **Changes on the index port in non-indexed modes.** A design that leaks the index value into those modes would move the address.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_RSVD   = 2'd3
  } amode_e;
endpackage

// File: rtl/vagu_ctrl.sv
// Sequence control: length capture, element counter, last and done.
module vagu_ctrl #(
  parameter int MAXVL = 64,
  parameter int VLW   = $clog2(MAXVL + 1),
  parameter int EIW   = $clog2(MAXVL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [VLW-1:0] vlen_i,
  input  logic           fire_i,
  output logic           load_o,
  output logic           busy_o,
  output logic [EIW-1:0] elem_o,
  output logic           last_o,
  output logic           done_o
);
  localparam logic [VLW-1:0] MAXV = VLW'(MAXVL);

  logic           busy_q, done_q;
  logic [EIW-1:0] elem_q, lastidx_q;
  logic [VLW-1:0] vlen_eff;

  assign vlen_eff = (vlen_i > MAXV) ? MAXV : vlen_i;
  assign load_o   = start_i && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      elem_q    <= '0;
      lastidx_q <= '0;
    end else if (load_o) begin
      elem_q <= '0;
      if (vlen_eff == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        busy_q    <= 1'b1;
        done_q    <= 1'b0;
        lastidx_q <= EIW'(vlen_eff - VLW'(1));
      end
    end else if (fire_i) begin
      if (last_o) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        elem_q <= elem_q + EIW'(1);
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign elem_o = elem_q;
  assign last_o = busy_q && (elem_q == lastidx_q);
  assign done_o = done_q;
endmodule

// File: rtl/vagu_offset.sv
// Captures mode, base and stride; forms the per-element offset.
module vagu_offset
  import vagu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int EIW      = 6,
  parameter bit USE_MULT = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  amode_e         mode_i,
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  stride_i,
  input  logic           fire_i,
  input  logic [EIW-1:0] elem_i,
  input  logic [AW-1:0]  idx_val_i,
  output logic [AW-1:0]  base_o,
  output logic [AW-1:0]  off_o
);
  amode_e        mode_q;
  logic [AW-1:0] base_q, stride_q, stride_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= AM_UNIT;
      base_q   <= '0;
      stride_q <= '0;
    end else if (load_i) begin
      mode_q   <= mode_i;
      base_q   <= base_i;
      stride_q <= stride_i;
    end
  end

  generate
    if (USE_MULT) begin : g_mult
      assign stride_off = AW'(elem_i) * stride_q;
    end else begin : g_accum
      logic [AW-1:0] acc_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (load_i) acc_q <= '0;
        else if (fire_i) acc_q <= acc_q + stride_q;
      end
      assign stride_off = acc_q;
    end
  endgenerate

  always_comb begin
    unique case (mode_q)
      AM_STRIDE: off_o = stride_off;
      AM_INDEX:  off_o = idx_val_i;
      default:   off_o = AW'(elem_i);
    endcase
  end

  assign base_o = base_q;
endmodule

// File: rtl/vagu_addr.sv
// Final add and element-to-byte scaling, both modulo 2^AW.
module vagu_addr #(
  parameter int AW     = 32,
  parameter int ESHIFT = 3
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] off_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] byte_o
);
  assign addr_o = base_i + off_i;
  assign byte_o = addr_o << ESHIFT;
endmodule

// File: rtl/vec_agu.sv
module vec_agu
  import vagu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int MAXVL    = 64,
  parameter int ESHIFT   = 3,
  parameter bit USE_MULT = 1'b0,
  localparam int VLW     = $clog2(MAXVL + 1),
  localparam int EIW     = $clog2(MAXVL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     mode_i,
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  stride_i,
  input  logic [VLW-1:0] vlen_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [EIW-1:0] idx_elem_o,
  input  logic [AW-1:0]  idx_val_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [AW-1:0]  out_addr_o,
  output logic [AW-1:0]  out_byte_addr_o,
  output logic [EIW-1:0] out_elem_o,
  output logic           out_last_o
);
  logic           load, fire;
  logic [EIW-1:0] elem;
  logic [AW-1:0]  base_q, off;

  assign fire = out_valid_o && out_ready_i;

  vagu_ctrl #(.MAXVL(MAXVL), .VLW(VLW), .EIW(EIW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vlen_i(vlen_i),
    .fire_i(fire), .load_o(load), .busy_o(busy_o), .elem_o(elem),
    .last_o(out_last_o), .done_o(done_o)
  );

  vagu_offset #(.AW(AW), .EIW(EIW), .USE_MULT(USE_MULT)) u_off (
    .clk(clk), .rst_n(rst_n), .load_i(load), .mode_i(amode_e'(mode_i)),
    .base_i(base_i), .stride_i(stride_i), .fire_i(fire), .elem_i(elem),
    .idx_val_i(idx_val_i), .base_o(base_q), .off_o(off)
  );

  vagu_addr #(.AW(AW), .ESHIFT(ESHIFT)) u_addr (
    .base_i(base_q), .off_i(off), .addr_o(out_addr_o), .byte_o(out_byte_addr_o)
  );

  assign out_valid_o = busy_o;
  assign out_elem_o  = elem;
  assign idx_elem_o  = elem;
endmodule

// File: rtl/vagu_chk.sv
module vagu_chk #(
  parameter int AW  = 32,
  parameter int VLW = 7,
  parameter int EIW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [1:0]     mode_i,
  input logic [AW-1:0]  stride_i,
  input logic [VLW-1:0] vlen_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [EIW-1:0] idx_elem_o,
  input logic           out_valid_o,
  input logic           out_ready_i,
  input logic [AW-1:0]  out_addr_o,
  input logic [EIW-1:0] out_elem_o,
  input logic           out_last_o
);
  logic [1:0]    mode_c;
  logic [AW-1:0] stride_c;
  logic          fire;
  assign fire = out_valid_o && out_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_c   <= 2'd0;
      stride_c <= '0;
    end else if (start_i && !busy_o) begin
      mode_c   <= mode_i;
      stride_c <= stride_i;
    end
  end

  p_start_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && vlen_i != '0) |=> (out_valid_o && out_elem_o == '0));
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_last_o && (mode_c == 2'd0 || mode_c == 2'd3))
      |=> out_addr_o == $past(out_addr_o) + AW'(1));
  p_stride_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_last_o && mode_c == 2'd1)
      |=> out_addr_o == $past(out_addr_o) + stride_c);
  p_index_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> idx_elem_o == out_elem_o);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && mode_c != 2'd2)
      |=> (out_valid_o && $stable(out_addr_o) && $stable(out_elem_o) && $stable(out_last_o)));
  p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_last_o) |=> out_elem_o == EIW'($past(out_elem_o) + EIW'(1)));
  p_last_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last_o) |=> (!out_valid_o && done_o));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !(start_i && !busy_o)) |=> !done_o);
  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && vlen_i == '0) |=> (done_o && !out_valid_o));
endmodule

bind vec_agu vagu_chk #(.AW(AW), .VLW(VLW), .EIW(EIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
  .stride_i(stride_i), .vlen_i(vlen_i), .busy_o(busy_o), .done_o(done_o),
  .idx_elem_o(idx_elem_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_addr_o(out_addr_o), .out_elem_o(out_elem_o), .out_last_o(out_last_o)
);

// File: tb/test_vec_agu.sv
module test_vec_agu;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] base;
    logic [31:0] stride;
    logic [6:0]  vlen;
    logic [3:0]  rdy;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0000_1000, 32'd0,          7'd5,   4'hF},
    '{2'd1, 32'h0000_2000, 32'd3,          7'd8,   4'b1010},
    '{2'd1, 32'h0000_0040, 32'hFFFF_FFFC,  7'd20,  4'hF},
    '{2'd2, 32'h0000_3000, 32'd9,          7'd10,  4'b0110},
    '{2'd0, 32'hFFFF_FFFE, 32'd0,          7'd4,   4'b1101},
    '{2'd1, 32'h0000_0000, 32'h1000_0000,  7'd64,  4'hF},
    '{2'd0, 32'h0000_0800, 32'd0,          7'd100, 4'hF},
    '{2'd3, 32'h0000_0010, 32'd7,          7'd3,   4'hF}
  };

  logic        clk = 0, rst_n = 0, start = 0, ready = 0;
  logic [1:0]  mode = 0;
  logic [31:0] base = 0, stride = 0, idx_bias = 0;
  logic [6:0]  vlen = 0;
  logic        busy, done, valid, last;
  logic [5:0]  idx_elem, elem;
  logic [31:0] idx_val, addr, baddr;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] idx_of(input int i);
    return 32'(i * i - 50);
  endfunction
  assign idx_val = idx_of(int'(idx_elem)) + idx_bias;

  vec_agu i_vec_agu (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .base_i(base),
    .stride_i(stride), .vlen_i(vlen), .busy_o(busy), .done_o(done),
    .idx_elem_o(idx_elem), .idx_val_i(idx_val), .out_valid_o(valid),
    .out_ready_i(ready), .out_addr_o(addr), .out_byte_addr_o(baddr),
    .out_elem_o(elem), .out_last_o(last)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input vec_t v, input int i);
    case (v.mode)
      2'd1:    return v.base + 32'(i) * v.stride;
      2'd2:    return v.base + idx_of(i);
      default: return v.base + 32'(i);
    endcase
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int n, i, cyc;
    n = (v.vlen > 7'd64) ? 64 : int'(v.vlen);
    mode = v.mode; base = v.base; stride = v.stride; vlen = v.vlen; start = 1;
    tick();
    start = 0;
    i = 0; cyc = 0;
    while (i < n && cyc < 1000) begin
      ready = v.rdy[cyc % 4];
      chk("R2 valid during run", 32'(valid), 32'd1);
      chk("R7 element order", 32'(elem), 32'(i));
      chk("R3/R4/R5 address", addr, exp_addr(v, i));
      chk("R6 byte address", baddr, exp_addr(v, i) << 3);
      chk("R8 last flag", 32'(last), 32'(i == n - 1));
      if (ready) i++;
      tick();
      cyc++;
    end
    ready = 0;
    chk("R8 valid low after last", 32'(valid), 32'd0);
    chk("R8 done pulse", 32'(done), 32'd1);
    chk("R10 element count", 32'(i), 32'(n));
    tick();
    chk("R8 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(valid), 32'd0);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 done after reset", 32'(done), 32'd0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R9: zero length
    mode = 2'd0; base = 32'h77; vlen = 0; start = 1;
    tick();
    start = 0;
    chk("R9 done after zero length", 32'(done), 32'd1);
    chk("R9 no valid on zero length", 32'(valid), 32'd0);
    tick();
    chk("R9 done cleared", 32'(done), 32'd0);
    chk("R9 still no valid", 32'(valid), 32'd0);

    // R2/R7: start while busy is ignored, stall holds outputs
    mode = 2'd0; base = 32'h500; vlen = 3; start = 1; ready = 0;
    tick();
    start = 0;
    tick();
    base = 32'h900; vlen = 1; mode = 2'd1; stride = 32'd5; start = 1;
    tick();
    start = 0;
    chk("R2 start while busy ignored", addr, 32'h500);
    chk("R7 element held under stall", 32'(elem), 32'd0);
    // R5: index input has no effect in contiguous mode
    idx_bias = 32'h1234;
    #1;
    chk("R5 index ignored in unit mode", addr, 32'h500);
    idx_bias = 0;
    ready = 1;
    tick();
    chk("R7 advance after accept", addr, 32'h501);
    tick();
    chk("R2 third element from first start", addr, 32'h502);
    chk("R8 last on third", 32'(last), 32'd1);
    tick();
    ready = 0;
    chk("R2 sequence ended with length 3", 32'(valid), 32'd0);

    // R5: index input is used in indexed mode
    mode = 2'd2; base = 32'h100; vlen = 2; start = 1;
    tick();
    start = 0;
    idx_bias = 32'h10;
    #1;
    chk("R5 index used in indexed mode", addr, 32'h100 + idx_of(0) + 32'h10);
    idx_bias = 0;
    ready = 1;
    tick(); tick();
    ready = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule